// File: doc/BRIEF.md
# Level-Prioritized Interrupt Controller

This block collects 32 level-sensitive interrupt requests and presents one of them to a CPU on a single interrupt line. Each request line has its own 3-bit priority level held in a small register file on a simple address/data bus. A level of zero parks a source. A global threshold admits only sources whose level lies strictly above it. A global enable gates the CPU line.

Every clock cycle the controller picks a winner from the current inputs: the highest level wins, and a tie goes to the lowest source number. It registers the winner into a status word, and registers the interrupt line next to it. Software reads the status word to learn which source to service. A flag in that word says whether any source qualified at all.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all level fields, the enable bit and the threshold are 0, `irq_out` is low, and the status word reads 0x0001_0000.
- R2: Level register k (k = 0..7) sits at byte address 0x10 + 4k. It holds the 3-bit levels of sources 2k in bits [2:0], 2k+1 in bits [10:8], 2k+16 in bits [18:16] and 2k+17 in bits [26:24]. Every other bit reads 0 and ignores writes.
- R3: A source whose level is 0 never qualifies, whatever its input.
- R4: A source qualifies only when its input is high and its level is strictly greater than the threshold. The threshold is held in bits [2:0] at address 0x40, and a threshold of 6 admits only level 7.
- R5: Among qualifying sources the highest level wins. On equal levels the lowest source number wins.
- R6: `irq_out` is high exactly when the enable bit (bit 0 at address 0x00) is set and at least one source qualifies. It is registered, so it follows the inputs one clock later.
- R7: The status word at address 0xA0 holds the winning source number in bits [4:0] and a none-pending flag in bit 16. The flag is 1, with number 0, when nothing qualifies. The word is registered one clock after the inputs and does not depend on the enable bit.
- R8: A read of any unmapped address returns 0. Writes to the status word or to unmapped addresses change no readable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 32 | Level-sensitive interrupt request lines, one per source |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
Directed patterns set up two requests at the same level to show that the lower number wins. They then raise one of them above the other to show that level beats number. A parked source that is held high shows that level 0 is excluded. A source at level 6 under a threshold of 6 shows that the threshold comparison is strict. With the enable bit cleared, the status word must still name a winner while the line stays low. Random request vectors, level words and small thresholds then drive many mixed contests. Each contest is scored against a bench model of the arbitration. Full 32-bit random level writes show that the unused bits are masked.

// File: rtl/lpic_pkg.sv
`timescale 1ns/1ps
package lpic_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_LVL0 = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_THR  = 8'h40;
  localparam logic [ADDR_W-1:0] ADR_STAT = 8'hA0;
  localparam int unsigned FIELD_STRIDE = 8;   // odd neighbour field offset
  localparam int unsigned HALF_OFS     = 16;  // upper-half source field offset
  localparam int unsigned NONE_BIT     = 16;  // none-pending flag in status
endpackage

// File: rtl/lpic_regs.sv
`timescale 1ns/1ps
module lpic_regs
  import lpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     en_o,
  output logic [LVL_W-1:0]         thr_o,
  output logic [NUM_SRC*LVL_W-1:0] lvl_o
);
  localparam int unsigned HALF = NUM_SRC / 2;

  logic en_q, en_d, en_ld;
  logic [LVL_W-1:0] thr_q, thr_d;
  logic thr_ld;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_comb begin
    en_ld  = we && (addr == ADR_CTRL);
    en_d   = wdata[0];
    thr_ld = we && (addr == ADR_THR);
    thr_d  = wdata[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      if (en_ld)  en_q  <= en_d;
      if (thr_ld) thr_q <= thr_d;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int unsigned REG_IX = (s % HALF) / 2;
    localparam int unsigned POS    = ((s >= HALF) ? HALF_OFS : 0)
                                   + ((s % 2 == 1) ? FIELD_STRIDE : 0);
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_LVL0 + ADDR_W'(4 * REG_IX);
    logic             ld;
    logic [LVL_W-1:0] d, q;

    always_comb begin
      ld = we && (addr == MY_ADR);
      d  = wdata[POS +: LVL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign lvl_o[s*LVL_W +: LVL_W] = q;
  end

  assign en_o  = en_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/lpic_arb.sv
`timescale 1ns/1ps
module lpic_arb #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       src,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]         thr,
  output logic                     any_o,
  output logic [ID_W-1:0]          id_o
);
  logic [LVL_W-1:0] best;

  // Start from the threshold: only strictly higher levels can win, and the
  // strict compare keeps the lowest index on a tie.
  always_comb begin
    best  = thr;
    any_o = 1'b0;
    id_o  = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src[s] && (lvl[s*LVL_W +: LVL_W] > best)) begin
        best  = lvl[s*LVL_W +: LVL_W];
        any_o = 1'b1;
        id_o  = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl
  import lpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] src_in,
  output logic        irq_out
);
  localparam int unsigned ID_W  = $clog2(NUM_SRC);
  localparam int unsigned HALF  = NUM_SRC / 2;
  localparam int unsigned N_LREG = NUM_SRC / 4;

  logic                     ctl_en;
  logic [LVL_W-1:0]         ctl_thr;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     arb_any;
  logic [ID_W-1:0]          arb_id;

  logic            irq_q, irq_d;
  logic            stat_none_q, stat_none_d;
  logic [ID_W-1:0] stat_id_q, stat_id_d;

  lpic_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .en_o(ctl_en), .thr_o(ctl_thr), .lvl_o(lvl_flat)
  );

  lpic_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .src(src_in[NUM_SRC-1:0]), .lvl(lvl_flat), .thr(ctl_thr),
    .any_o(arb_any), .id_o(arb_id)
  );

  always_comb begin
    irq_d       = ctl_en && arb_any;
    stat_none_d = !arb_any;
    stat_id_d   = arb_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q       <= 1'b0;
      stat_none_q <= 1'b1;
      stat_id_q   <= '0;
    end else begin
      irq_q       <= irq_d;
      stat_none_q <= stat_none_d;
      stat_id_q   <= stat_id_d;
    end
  end

  assign irq_out = irq_q;

  // Read path: combinational decode of the byte address.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_CTRL) begin
      bus_rdata[0] = ctl_en;
    end else if (bus_addr == ADR_THR) begin
      bus_rdata[LVL_W-1:0] = ctl_thr;
    end else if (bus_addr == ADR_STAT) begin
      bus_rdata[ID_W-1:0] = stat_id_q;
      bus_rdata[NONE_BIT] = stat_none_q;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (bus_addr == ADR_LVL0 + 8'(4 * ((s % HALF) / 2))) begin
          bus_rdata[((s >= HALF) ? HALF_OFS : 0) + ((s % 2 == 1) ? FIELD_STRIDE : 0) +: LVL_W]
            = lvl_flat[s*LVL_W +: LVL_W];
        end
      end
    end
  end

  logic unused_nlreg;
  assign unused_nlreg = (N_LREG == 0);
endmodule

// File: rtl/lpic_chk.sv
`timescale 1ns/1ps
module lpic_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [31:0]     src_in,
  input logic            irq_out,
  input logic            ctl_en,
  input logic            stat_none_q,
  input logic [ID_W-1:0] stat_id_q
);
  localparam logic [31:0] FMASK = 32'((1 << LVL_W) - 1);
  localparam logic [31:0] LVL_KEEP = FMASK | (FMASK << 8) | (FMASK << 16) | (FMASK << 24);

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(ctl_en));

  // R6
  irq_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_en) |-> (irq_out == !stat_none_q));

  // R7
  none_means_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_none_q |-> (stat_id_q == '0));

  // R4
  winner_was_requesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_none_q |-> ((($past(src_in) >> stat_id_q) & 32'd1) == 32'd1));

  // R2
  level_spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 8'h10 && bus_addr <= 8'h2C) |-> ((bus_rdata & ~LVL_KEEP) == 32'd0));

  // R8
  misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0));
endmodule

bind lvl_irq_ctrl lpic_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_lpic_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .src_in(src_in), .irq_out(irq_out), .ctl_en(ctl_en),
  .stat_none_q(stat_none_q), .stat_id_q(stat_id_q)
);

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src_in;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0] m_lvl [32];
  logic       m_en;
  logic [2:0] m_thr;

  always #4 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int fpos(input int s);
    return ((s >= 16) ? 16 : 0) + ((s % 2 == 1) ? 8 : 0);
  endfunction

  function automatic logic [31:0] exp_lreg(input int k);
    logic [31:0] v = '0;
    for (int s = 0; s < 32; s++)
      if (((s % 16) / 2) == k) v[fpos(s) +: 3] = m_lvl[s];
    return v;
  endfunction

  function automatic logic [31:0] exp_status(input logic [31:0] src);
    logic [2:0] best = m_thr;
    logic [31:0] v = 32'h0001_0000;
    for (int s = 0; s < 32; s++)
      if (src[s] && m_lvl[s] > best) begin
        best = m_lvl[s];
        v = 32'(s);
      end
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h00) m_en = d[0];
    if (a == 8'h40) m_thr = d[2:0];
    for (int k = 0; k < 8; k++)
      if (a == 8'(8'h10 + 4 * k))
        for (int s = 0; s < 32; s++)
          if (((s % 16) / 2) == k) m_lvl[s] = d[fpos(s) +: 3];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Drive sources, let two edges pass, compare line and status word.
  task automatic apply_check(input logic [31:0] src, input string req);
    logic [31:0] st, es;
    @(negedge clk);
    src_in = src;
    @(negedge clk);
    @(negedge clk);
    es = exp_status(src);
    chk(irq_out == (m_en && !es[16]), {req, " irq_out"}, 32'(irq_out),
        32'(m_en && !es[16]));
    rd(8'hA0, st);
    chk(st == es, {req, " status"}, st, es);
  endtask

  task automatic clear_levels();
    for (int k = 0; k < 8; k++) wr(8'(8'h10 + 4 * k), 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, e;
    void'($urandom(32'd4242));
    for (int s = 0; s < 32; s++) m_lvl[s] = '0;
    m_en = 1'b0; m_thr = '0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_out == 1'b0, "R1 irq low", 32'(irq_out), 0);
    rd(8'hA0, r); chk(r == 32'h0001_0000, "R1 status", r, 32'h0001_0000);
    rd(8'h00, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(8'h40, r); chk(r == 0, "R1 thr", r, 0);
    for (int k = 0; k < 8; k++) begin
      rd(8'(8'h10 + 4 * k), r); chk(r == 0, "R1 level reg", r, 0);
    end

    // R2 field map and masking
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, r); chk(r == 32'h0707_0707, "R2 mask", r, 32'h0707_0707);
    wr(8'h2C, 32'h0305_0601);
    rd(8'h2C, r); chk(r == 32'h0305_0601, "R2 fields", r, 32'h0305_0601);
    chk(m_lvl[14] == 3'd1 && m_lvl[15] == 3'd6 && m_lvl[30] == 3'd5 && m_lvl[31] == 3'd3,
        "R2 model map", 0, 0);
    clear_levels();
    wr(8'h00, 32'h1);

    // R5 tie between sources 3 and 20 at level 5
    wr(8'h14, 32'h0000_0500);   // source 3 in [10:8]
    wr(8'h18, 32'h0005_0000);   // source 20 in [18:16]
    apply_check(32'h0010_0008, "R5 tie lowest");
    chk(exp_status(32'h0010_0008) == 32'd3, "R5 tie expect", 0, 0);
    wr(8'h18, 32'h0007_0000);
    apply_check(32'h0010_0008, "R5 higher level");

    // R3 parked source held high
    clear_levels();
    apply_check(32'hFFFF_FFFF, "R3 level zero");
    rd(8'hA0, r); chk(r == 32'h0001_0000, "R3 none", r, 32'h0001_0000);

    // R4 strict threshold
    wr(8'h40, 32'h6);
    wr(8'h10, 32'h0000_0600);   // source 1 at 6
    apply_check(32'h0000_0002, "R4 level equals thr");
    wr(8'h10, 32'h0700_0600);   // source 17 at 7
    apply_check(32'h0002_0002, "R4 top level");
    rd(8'hA0, r); chk(r == 32'd17, "R4 winner 17", r, 32'd17);

    // R6 one-cycle latency
    @(negedge clk); src_in = 32'h0;
    @(negedge clk);
    chk(irq_out == 1'b0, "R6 drop", 32'(irq_out), 0);
    src_in = 32'h0002_0000;
    chk(irq_out == 1'b0, "R6 before edge", 32'(irq_out), 0);
    @(negedge clk);
    chk(irq_out == 1'b1, "R6 after edge", 32'(irq_out), 1);

    // R7 status with enable off
    wr(8'h00, 32'h0);
    apply_check(32'h0002_0000, "R7 disabled");
    rd(8'hA0, r); chk(r == 32'd17, "R7 status w/o enable", r, 32'd17);

    // R8 ignored writes and unmapped reads
    wr(8'hA0, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(8'hA0, r); chk(r == 32'd17, "R8 status write ignored", r, 32'd17);
    rd(8'h44, r); chk(r == 0, "R8 unmapped 0x44", r, 0);
    rd(8'h30, r); chk(r == 0, "R8 unmapped 0x30", r, 0);
    rd(8'h0C, r); chk(r == 0, "R8 unmapped 0x0C", r, 0);
    rd(8'h40, r); chk(r == 32'd6, "R8 thr kept", r, 32'd6);
    rd(8'h00, r); chk(r == 0, "R8 ctrl kept", r, 0);
    for (int k = 0; k < 8; k++) begin
      rd(8'(8'h10 + 4 * k), r); e = exp_lreg(k);
      chk(r == e, "R8 levels kept", r, e);
    end

    // R4 R5 R6 R7 random contests
    wr(8'h00, 32'h1);
    wr(8'h40, 32'h0);
    for (int it = 0; it < 300; it++) begin
      int k = $urandom_range(0, 7);
      wr(8'(8'h10 + 4 * k), $urandom());
      if ($urandom_range(0, 9) == 0) wr(8'h40, 32'($urandom_range(0, 3)));
      if ($urandom_range(0, 15) == 0) wr(8'h00, 32'($urandom_range(0, 1)));
      apply_check($urandom() & $urandom(), "R5 random");
      if (it % 10 == 0) begin
        rd(8'(8'h10 + 4 * k), r); e = exp_lreg(k);
        chk(r == e, "R2 random readback", r, e);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule